// File: doc/BRIEF.md
# Power Management Event Register Bank

This block watches twelve general-purpose wake inputs and keeps a sticky status bit for each. It synchronizes every input and captures its rising edges. A source whose own enable is set also latches a single global event flag. When the global enable allows it, that flag drives an active-low event output.

Software reaches the bank through a byte-wide register port with a 4-bit offset, write data, a write strobe and combinational read data. Status bits are cleared by writing 1 to them. The flops are reset only by the standby-domain power-on reset, `stby_rst_n`. No other reset in the system reaches them, so wake history survives main-supply and software resets.

Register offsets:
- 0x00: global status, bit 0.
- 0x04: global enable, bit 0.
- 0x08: wake status for sources 0–7.
- 0x09: wake status for sources 8–11.
- 0x0A and 0x0B: the per-source enables, laid out the same way as 0x08 and 0x09.

Top module: `pme_bank`

## Requirements
- R1: After `stby_rst_n` is asserted, every register reads 0x00 and `pme_n` is 1.
- R2: A rising edge on `wake_in[i]` sets wake status bit i on the third rising clock edge after the input rises, whatever the per-source and global enables are. Source i is mapped as follows: sources 0–7 are bits 7:0 of offset 0x08, and sources 8–11 are bits 3:0 of offset 0x09. An input held high sets the bit only once.
- R3: Writing 1 to a wake status bit clears that bit. Writing 0 leaves it unchanged.
- R4: Bits 7:4 of offset 0x09 read 0 and ignore writes. Offsets 0x01–0x03, 0x05–0x07 and 0x0C–0x0F read 0x00 and ignore writes.
- R5: The per-source enables are read/write. Sources 0–7 are in bits 7:0 of offset 0x0A, and sources 8–11 are in bits 3:0 of offset 0x0B. Bits 7:4 of 0x0B read 0.
- R6: The global status bit (offset 0x00, bit 0) sets on the same edge as the wake status bit of a source whose enable is 1. An edge on a disabled source does not set it.
- R7: The global enable (offset 0x04, bit 0) is read/write, and bits 7:1 of that offset read 0. `pme_n` is 0 exactly when both the global status and the global enable are 1.
- R8: Writing 1 to bit 0 of offset 0x00 clears the global status, and `pme_n` returns to 1 after that edge. Writing 0 to that bit has no effect, and the write leaves the wake status bits unchanged.
- R9: If a hardware set and a write-1-clear of the same bit fall on the same clock edge, the bit ends up set. This holds both for a wake status bit and for the global status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| stby_rst_n | input | 1 | Standby power-on reset, active low, asynchronous |
| wake_in | input | 12 | Asynchronous wake sources |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pme_n | output | 1 | Active-low power-management event |

## Verification
Almost every piece of state in this block can be read back, so a wrong bit shows up on `reg_rdata` in the same cycle the offset is presented. A lost or spurious capture is visible three clock edges after the input moves. A wrong global flag or gate shows on `pme_n` immediately after the edge that should have changed it. The collision cases need the write strobe placed exactly on the capture edge. If they are wrong, the result is a silently cleared bit and an output that never asserts.

// File: rtl/pme_bank.sv
module pme_bank #(
  parameter int N_LO = 8,
  parameter int N_HI = 4
) (
  input  logic                 clk,
  input  logic                 stby_rst_n,
  input  logic [N_LO+N_HI-1:0] wake_in,
  input  logic [3:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  input  logic                 reg_we,
  output logic [7:0]           reg_rdata,
  output logic                 pme_n
);
  localparam int N = N_LO + N_HI;
  localparam logic [3:0] A_GSTS   = 4'h0;
  localparam logic [3:0] A_GEN    = 4'h4;
  localparam logic [3:0] A_STS_LO = 4'h8;
  localparam logic [3:0] A_STS_HI = 4'h9;
  localparam logic [3:0] A_EN_LO  = 4'hA;
  localparam logic [3:0] A_EN_HI  = 4'hB;

  logic [N-1:0] s1, s2, s3;
  logic [N-1:0] edge_det, wake_sts, src_en, clr_sts;
  logic         gsts, gen, set_g, clr_g;

  wire wr_gsts   = reg_we && reg_addr == A_GSTS;
  wire wr_gen    = reg_we && reg_addr == A_GEN;
  wire wr_sts_lo = reg_we && reg_addr == A_STS_LO;
  wire wr_sts_hi = reg_we && reg_addr == A_STS_HI;
  wire wr_en_lo  = reg_we && reg_addr == A_EN_LO;
  wire wr_en_hi  = reg_we && reg_addr == A_EN_HI;

  assign edge_det = s2 & ~s3;
  assign clr_sts  = {wr_sts_hi ? reg_wdata[N_HI-1:0] : {N_HI{1'b0}},
                     wr_sts_lo ? reg_wdata[N_LO-1:0] : {N_LO{1'b0}}};
  assign set_g    = |(edge_det & src_en);
  assign clr_g    = wr_gsts && reg_wdata[0];
  assign pme_n    = ~(gsts & gen);

  always_ff @(posedge clk or negedge stby_rst_n) begin
    if (!stby_rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= wake_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge stby_rst_n) begin
    if (!stby_rst_n) begin
      wake_sts <= '0;
      src_en   <= '0;
      gsts     <= 1'b0;
      gen      <= 1'b0;
    end else begin
      wake_sts <= edge_det | (wake_sts & ~clr_sts);
      gsts     <= set_g | (gsts & ~clr_g);
      if (wr_gen)   gen <= reg_wdata[0];
      if (wr_en_lo) src_en[N_LO-1:0] <= reg_wdata[N_LO-1:0];
      if (wr_en_hi) src_en[N-1:N_LO] <= reg_wdata[N_HI-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_GSTS:   reg_rdata = {7'd0, gsts};
      A_GEN:    reg_rdata = {7'd0, gen};
      A_STS_LO: reg_rdata = 8'(wake_sts[N_LO-1:0]);
      A_STS_HI: reg_rdata = 8'(wake_sts[N-1:N_LO]);
      A_EN_LO:  reg_rdata = 8'(src_en[N_LO-1:0]);
      A_EN_HI:  reg_rdata = 8'(src_en[N-1:N_LO]);
      default:  reg_rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/pme_bank_chk.sv
module pme_bank_chk #(
  parameter int N = 12,
  parameter int N_HI = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   reg_addr,
  input logic [7:0]   reg_wdata,
  input logic         reg_we,
  input logic [7:0]   reg_rdata,
  input logic         pme_n,
  input logic [N-1:0] edge_det,
  input logic [N-1:0] wake_sts,
  input logic [N-1:0] src_en,
  input logic         gsts,
  input logic         gen
);
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det != '0) |=> ((wake_sts & $past(edge_det)) == $past(edge_det)));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sts == '0) |=> ((wake_sts & ~$past(edge_det)) == '0));

  a_r4_hi_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'h9) |-> ((reg_rdata >> N_HI) == 8'd0));

  a_r6_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!gsts && (edge_det & src_en) == '0) |=> !gsts);

  a_r7_output_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_n |-> (gen && gsts));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h0 && reg_wdata[0] && (edge_det & src_en) == '0) |=> (!gsts && pme_n));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_det & src_en) != '0) |=> gsts);
endmodule

bind pme_bank pme_bank_chk #(.N(N), .N_HI(N_HI)) u_chk (
  .clk(clk), .rst_n(stby_rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_rdata(reg_rdata), .pme_n(pme_n), .edge_det(edge_det),
  .wake_sts(wake_sts), .src_en(src_en), .gsts(gsts), .gen(gen)
);

// File: tb/sim_pme_bank.sv
module sim_pme_bank;
  logic        clk = 1'b0;
  logic        stby_rst_n = 1'b0;
  logic [11:0] wake_in = '0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic        pme_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit       is_pme;
    logic [3:0] addr;
    logic [7:0] exp;
    string    req;
  } item_t;
  item_t q[$];

  pme_bank u0 (.clk(clk), .stby_rst_n(stby_rst_n), .wake_in(wake_in), .reg_addr(reg_addr),
               .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .pme_n(pme_n));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.is_pme) begin
        if (pme_n !== it.exp[0]) begin
          errors++;
          $display("FAIL %s pme_n actual %b expected %b", it.req, pme_n, it.exp[0]);
        end
      end else if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s offset %h actual %h expected %h", it.req, it.addr, reg_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string r);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_pme = 0; it.addr = a; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic chk_pme(input bit e, input string r);
    item_t it;
    @(posedge clk); #1;
    it.is_pme = 1; it.addr = '0; it.exp = {7'd0, e}; it.req = r;
    q.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(posedge clk); #1;
    wake_in[i] = 1'b1;
    repeat (3) @(posedge clk);
    #1 wake_in[i] = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic collide(input int i, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wake_in[i] = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; wake_in[i] = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 stby_rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, 8'h00, "R1"); rd(4'h4, 8'h00, "R1"); rd(4'h8, 8'h00, "R1");
    rd(4'h9, 8'h00, "R1"); rd(4'hA, 8'h00, "R1"); rd(4'hB, 8'h00, "R1");
    chk_pme(1, "R1");

    // R2 capture with all enables off; exact latency on source 3
    @(posedge clk); #1 wake_in[3] = 1'b1;
    @(posedge clk); @(posedge clk); #1 reg_addr = 4'h8;
    #3 begin checks++; if (reg_rdata !== 8'h00) begin errors++;
      $display("FAIL R2 early set actual %h expected 00", reg_rdata); end end
    rd(4'h8, 8'h08, "R2");
    repeat (4) @(posedge clk);
    rd(4'h8, 8'h08, "R2 held");
    #1 wake_in[3] = 1'b0;
    rd(4'h0, 8'h00, "R6 no enable");
    pulse(9);
    rd(4'h9, 8'h02, "R2 high word");

    // R3/R4 write semantics
    wr(4'h8, 8'h00); rd(4'h8, 8'h08, "R3 write0");
    wr(4'h9, 8'hF0); rd(4'h9, 8'h02, "R4 reserved hi bits");
    wr(4'h8, 8'h08); rd(4'h8, 8'h00, "R3 clear");
    wr(4'h9, 8'h02); rd(4'h9, 8'h00, "R3 clear hi");
    wr(4'h1, 8'hFF); rd(4'h1, 8'h00, "R4");
    wr(4'h5, 8'hFF); rd(4'h5, 8'h00, "R4");
    wr(4'h7, 8'hFF); rd(4'h7, 8'h00, "R4");
    wr(4'hC, 8'hFF); rd(4'hC, 8'h00, "R4");
    wr(4'hF, 8'hFF); rd(4'hF, 8'h00, "R4");

    // R5 source enables
    wr(4'hA, 8'hA5); rd(4'hA, 8'hA5, "R5");
    wr(4'hB, 8'hFF); rd(4'hB, 8'h0F, "R5");

    // R7 global enable
    wr(4'h4, 8'hFF); rd(4'h4, 8'h01, "R7"); chk_pme(1, "R7 no status");

    // R6 gating by source enable
    pulse(1); rd(4'h0, 8'h00, "R6 disabled"); chk_pme(1, "R6");
    pulse(2); rd(4'h0, 8'h01, "R6 enabled"); chk_pme(0, "R7 asserted");
    wr(4'h4, 8'h00); chk_pme(1, "R7 gated"); rd(4'h0, 8'h01, "R7 status kept");
    wr(4'h4, 8'h01); chk_pme(0, "R7 reenable");

    // R8 global clear
    wr(4'h0, 8'hFE); rd(4'h0, 8'h01, "R8 write0"); chk_pme(0, "R8");
    wr(4'h0, 8'h01); rd(4'h0, 8'h00, "R8 clear"); chk_pme(1, "R8 released");
    rd(4'h8, 8'h06, "R8 wake bits kept");
    pulse(10); rd(4'h0, 8'h01, "R6 hi source"); rd(4'h9, 8'h04, "R2 src10");
    wr(4'h0, 8'h01); wr(4'h8, 8'hFF); wr(4'h9, 8'hFF);
    rd(4'h8, 8'h00, "R3"); rd(4'h0, 8'h00, "R8");

    // R9 collisions
    pulse(0); rd(4'h8, 8'h01, "R2");
    collide(0, 4'h8, 8'h01); rd(4'h8, 8'h01, "R9 wake bit");
    collide(0, 4'h0, 8'h01); rd(4'h0, 8'h01, "R9 global"); chk_pme(0, "R9");

    // R1 standby reset again
    @(posedge clk); #1 stby_rst_n = 1'b0;
    @(posedge clk); #1 stby_rst_n = 1'b1;
    rd(4'h0, 8'h00, "R1"); rd(4'h4, 8'h00, "R1"); rd(4'h8, 8'h00, "R1");
    rd(4'hA, 8'h00, "R1"); chk_pme(1, "R1");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule